// File: doc/BRIEF.md
# Codec Control Register Bank

This block holds the control state of an audio codec behind a 32-bit word-addressed bus. A 64-byte window holds sixteen 32-bit direct registers, selected by byte address bits 5:2. One direct register is an index pointer, and a second one acts as a data window. Accesses through the window reach one of thirty-two 8-bit indirect registers, chosen by the pointer.

Some entries have access rules of their own. The indirect bank has one write-only entry and two read-only entries, plus a version entry whose fixed bits cannot be overwritten. In the direct bank one register is read-only. A control register can launch a soft reset, which puts every register back to its power-on value while the control register keeps the value just written. The interrupt output exists so the block fits its socket, but no event drives it.

Top module: `codec_reg_bank`

## Requirements
- R1: After reset (rst_ni low), every direct register reads 0 and every indirect register reads 0, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R2: The word number is addr_i[5:2], and addr_i[1:0] is ignored. Direct registers other than 1, 2 and 4 store all 32 bits of a write. A write takes effect at the clock edge where wr_en_i is high, so a read in that same cycle returns the old value. rdata_o is combinational and follows rd_en_i in the same cycle, and it is 0 while rd_en_i is low.
- R3: The index is bits 4:0 of direct register 0. A read of word 1 returns the selected indirect register in rdata_o[7:0], with the upper bits zero. A write of word 1 stores wdata_i[7:0] into the selected indirect register.
- R4: Indirect register 3 reads as 0 through word 1, whatever was written to it.
- R5: Writes to indirect registers 11 and 25 through word 1 are ignored, so they keep reading 0x00 and 0xA0.
- R6: A write to indirect register 12 stores (wdata_i & 0x40) | 0x8A.
- R7: Writes to direct register 2 are ignored, and it always reads 0.
- R8: A write to direct register 4 stores wdata_i & 0x7F. When bit 0 of the write is clear, no other register changes.
- R9: A write to direct register 4 with wdata_i[0] set returns every other register to its R1 value on the next cycle. Register 4 holds the masked written value.
- R10: irq_o is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address within the window |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_en_i | input | 1 | Read strobe, returns data in the same cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when rd_en_i is low |
| irq_o | output | 1 | Interrupt, held low |

## Verification
Read data is combinational, so each read check drives rd_en_i and the address on a falling edge and samples rdata_o 1 time unit later, in the same cycle. A write lands at the next rising edge. Every check of a write's effect therefore reads in a later cycle, and the soft-reset checks start one full cycle after the triggering write. One directed case raises write and read strobes in the same cycle: it expects the old value before the edge and the new one after it.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int unsigned DIR_REGS_D = 16;
  localparam int unsigned DATA_W_D   = 32;
  localparam int unsigned IND_REGS_D = 32;
  localparam int unsigned IND_W_D    = 8;

  // direct word numbers
  localparam int unsigned W_INDEX  = 0;
  localparam int unsigned W_DATA   = 1;
  localparam int unsigned W_STATUS = 2;
  localparam int unsigned W_CTRL   = 4;
  localparam logic [31:0] CTRL_MASK = 32'h0000_007F;
  localparam int unsigned SRST_BIT  = 0;

  // indirect entries
  localparam int unsigned I_WO   = 3;
  localparam int unsigned I_RO   = 11;
  localparam int unsigned I_VER  = 12;
  localparam int unsigned I_ID   = 25;
  localparam logic [7:0]  VER_CODE = 8'h8A;
  localparam logic [7:0]  VER_KEEP = 8'h40;
  localparam logic [7:0]  ID_CODE  = 8'hA0;

  function automatic logic [7:0] ind_rst_val(int unsigned i);
    if (i == I_VER)     return VER_CODE;
    else if (i == I_ID) return ID_CODE;
    else                return 8'h00;
  endfunction
endpackage

// File: rtl/codec_bus_decode.sv
module codec_bus_decode
  import codec_regs_pkg::*;
#(
  parameter int unsigned BUS_AW = 6,
  parameter int unsigned DIR_AW = 4
) (
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              srst_bit_i,
  output logic [DIR_AW-1:0] word_o,
  output logic              dir_we_o,
  output logic              ind_we_o,
  output logic              soft_rst_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];
  assign word_o     = addr_i[BUS_AW-1:2];

  always_comb begin
    dir_we_o   = wr_en_i && (word_o != DIR_AW'(W_DATA)) && (word_o != DIR_AW'(W_STATUS));
    ind_we_o   = wr_en_i && (word_o == DIR_AW'(W_DATA));
    soft_rst_o = wr_en_i && (word_o == DIR_AW'(W_CTRL)) && srst_bit_i;
  end
endmodule

// File: rtl/codec_dir_bank.sv
module codec_dir_bank
  import codec_regs_pkg::*;
#(
  parameter int unsigned DIR_REGS = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned DIR_AW  = $clog2(DIR_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [DIR_AW-1:0] sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o [DIR_REGS]
);
  for (genvar g = 0; g < DIR_REGS; g++) begin : g_reg
    if (g == W_DATA || g == W_STATUS) begin : g_none
      assign q_o[g] = '0;
    end else begin : g_ff
      logic [DATA_W-1:0] d;
      always_comb d = (g == W_CTRL) ? (wdata_i & DATA_W'(CTRL_MASK)) : wdata_i;
      // store wins over soft reset (only the control word can coincide)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           q_o[g] <= '0;
        else if (we_i && sel_i == DIR_AW'(g))  q_o[g] <= d;
        else if (soft_rst_i)                   q_o[g] <= '0;
      end
    end
  end
endmodule

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
  import codec_regs_pkg::*;
#(
  parameter int unsigned IND_REGS = 32,
  parameter int unsigned IND_W    = 8,
  localparam int unsigned IND_AW  = $clog2(IND_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [IND_AW-1:0] idx_i,
  input  logic [IND_W-1:0]  wdata_i,
  output logic [IND_W-1:0]  rdata_o,
  output logic [IND_W-1:0]  q_o [IND_REGS]
);
  for (genvar g = 0; g < IND_REGS; g++) begin : g_reg
    localparam logic [IND_W-1:0] RST = IND_W'(ind_rst_val(g));
    if (g == I_RO || g == I_ID) begin : g_fixed
      assign q_o[g] = RST;
    end else begin : g_ff
      logic [IND_W-1:0] d;
      always_comb d = (g == I_VER) ? ((wdata_i & IND_W'(VER_KEEP)) | IND_W'(VER_CODE)) : wdata_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q_o[g] <= RST;
        else if (soft_rst_i)                  q_o[g] <= RST;
        else if (we_i && idx_i == IND_AW'(g)) q_o[g] <= d;
      end
    end
  end

  always_comb rdata_o = (idx_i == IND_AW'(I_WO)) ? '0 : q_o[idx_i];
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regs_pkg::*;
#(
  parameter int unsigned DIR_REGS = DIR_REGS_D,
  parameter int unsigned DATA_W   = DATA_W_D,
  parameter int unsigned IND_REGS = IND_REGS_D,
  parameter int unsigned IND_W    = IND_W_D,
  localparam int unsigned DIR_AW  = $clog2(DIR_REGS),
  localparam int unsigned IND_AW  = $clog2(IND_REGS),
  localparam int unsigned BUS_AW  = DIR_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DIR_AW-1:0] word;
  logic              dir_we, ind_we, soft_rst;
  logic [DATA_W-1:0] dir_q [DIR_REGS];
  logic [IND_W-1:0]  ind_q [IND_REGS];
  logic [IND_W-1:0]  ind_rd;
  logic [IND_AW-1:0] ind_idx;

  codec_bus_decode #(.BUS_AW(BUS_AW), .DIR_AW(DIR_AW)) u_dec (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .srst_bit_i(wdata_i[SRST_BIT]),
    .word_o    (word),
    .dir_we_o  (dir_we),
    .ind_we_o  (ind_we),
    .soft_rst_o(soft_rst)
  );

  codec_dir_bank #(.DIR_REGS(DIR_REGS), .DATA_W(DATA_W)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .we_i      (dir_we),
    .sel_i     (word),
    .wdata_i   (wdata_i),
    .q_o       (dir_q)
  );

  assign ind_idx = dir_q[W_INDEX][IND_AW-1:0];

  codec_ind_bank #(.IND_REGS(IND_REGS), .IND_W(IND_W)) u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .we_i      (ind_we),
    .idx_i     (ind_idx),
    .wdata_i   (wdata_i[IND_W-1:0]),
    .rdata_o   (ind_rd),
    .q_o       (ind_q)
  );

  always_comb begin
    if (!rd_en_i)                        rdata_o = '0;
    else if (word == DIR_AW'(W_DATA))    rdata_o = DATA_W'(ind_rd);
    else                                 rdata_o = dir_q[word];
  end

  assign irq_o = 1'b0;
endmodule

// File: rtl/codec_reg_bank_chk.sv
module codec_reg_bank_chk
  import codec_regs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IND_REGS = 32,
  parameter int unsigned IND_W    = 8,
  parameter int unsigned BUS_AW   = 6,
  localparam int unsigned IND_AW  = $clog2(IND_REGS),
  localparam int unsigned DIR_AW  = BUS_AW - 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [IND_AW-1:0] idx_i,
  input logic [DATA_W-1:0] index_q_i,
  input logic [DATA_W-1:0] ctrl_q_i,
  input logic [IND_W-1:0]  ind_q_i [IND_REGS]
);
  logic [DIR_AW-1:0] word;
  assign word = addr_i[BUS_AW-1:2];

  // R2
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

  // R3
  data_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == DIR_AW'(W_DATA) && idx_i != IND_AW'(I_RO) &&
     idx_i != IND_AW'(I_ID) && idx_i != IND_AW'(I_VER))
    |=> ind_q_i[$past(idx_i)] == $past(wdata_i[IND_W-1:0]));

  // R4
  wo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && word == DIR_AW'(W_DATA) && idx_i == IND_AW'(I_WO)) |-> rdata_o == '0);

  // R6
  ver_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_q_i[I_VER] & ~IND_W'(VER_KEEP)) == IND_W'(VER_CODE));

  // R8
  ctrl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == DIR_AW'(W_CTRL)) |=> ctrl_q_i == ($past(wdata_i) & DATA_W'(CTRL_MASK)));

  // R9
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == DIR_AW'(W_CTRL) && wdata_i[SRST_BIT])
    |=> index_q_i == '0 && ind_q_i[I_VER] == IND_W'(VER_CODE));
endmodule

bind codec_reg_bank codec_reg_bank_chk #(
  .DATA_W(DATA_W), .IND_REGS(IND_REGS), .IND_W(IND_W), .BUS_AW(BUS_AW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .idx_i    (ind_idx),
  .index_q_i(dir_q[0]),
  .ctrl_q_i (dir_q[4]),
  .ind_q_i  (ind_q)
);

// File: tb/codec_reg_bank_test.sv
module codec_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 44;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_reg_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {write, req, addr, data, expected}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 4'd1, 6'h00, 32'h0,        32'h0},        // R1
    {1'b0, 4'd1, 6'h08, 32'h0,        32'h0},        // R1
    {1'b0, 4'd1, 6'h3C, 32'h0,        32'h0},        // R1
    {1'b1, 4'd1, 6'h00, 32'd12,       32'h0},
    {1'b0, 4'd1, 6'h04, 32'h0,        32'h8A},       // R1
    {1'b1, 4'd1, 6'h00, 32'd25,       32'h0},
    {1'b0, 4'd1, 6'h04, 32'h0,        32'hA0},       // R1
    {1'b1, 4'd2, 6'h0C, 32'hDEADBEEF, 32'h0},
    {1'b0, 4'd2, 6'h0F, 32'h0,        32'hDEADBEEF}, // R2 low bits ignored
    {1'b1, 4'd2, 6'h3C, 32'h12345678, 32'h0},
    {1'b0, 4'd2, 6'h3C, 32'h0,        32'h12345678}, // R2
    {1'b1, 4'd3, 6'h00, 32'hFFFFFFE5, 32'h0},
    {1'b0, 4'd3, 6'h00, 32'h0,        32'hFFFFFFE5}, // R3 index reg full width
    {1'b0, 4'd3, 6'h04, 32'h0,        32'h0},        // R3
    {1'b1, 4'd3, 6'h04, 32'h1C3,      32'h0},
    {1'b0, 4'd3, 6'h04, 32'h0,        32'hC3},       // R3
    {1'b1, 4'd3, 6'h00, 32'd7,        32'h0},
    {1'b1, 4'd3, 6'h04, 32'h55,       32'h0},
    {1'b1, 4'd3, 6'h00, 32'd5,        32'h0},
    {1'b0, 4'd3, 6'h04, 32'h0,        32'hC3},       // R3
    {1'b1, 4'd3, 6'h00, 32'd7,        32'h0},
    {1'b0, 4'd3, 6'h04, 32'h0,        32'h55},       // R3
    {1'b1, 4'd4, 6'h00, 32'd3,        32'h0},
    {1'b1, 4'd4, 6'h04, 32'h77,       32'h0},
    {1'b0, 4'd4, 6'h04, 32'h0,        32'h0},        // R4
    {1'b1, 4'd5, 6'h00, 32'd11,       32'h0},
    {1'b1, 4'd5, 6'h04, 32'hFF,       32'h0},
    {1'b0, 4'd5, 6'h04, 32'h0,        32'h0},        // R5
    {1'b1, 4'd5, 6'h00, 32'd25,       32'h0},
    {1'b1, 4'd5, 6'h04, 32'h11,       32'h0},
    {1'b0, 4'd5, 6'h04, 32'h0,        32'hA0},       // R5
    {1'b1, 4'd6, 6'h00, 32'd12,       32'h0},
    {1'b1, 4'd6, 6'h04, 32'hFF,       32'h0},
    {1'b0, 4'd6, 6'h04, 32'h0,        32'hCA},       // R6
    {1'b1, 4'd6, 6'h04, 32'h00,       32'h0},
    {1'b0, 4'd6, 6'h04, 32'h0,        32'h8A},       // R6
    {1'b1, 4'd6, 6'h04, 32'h40,       32'h0},
    {1'b0, 4'd6, 6'h04, 32'h0,        32'hCA},       // R6
    {1'b1, 4'd7, 6'h08, 32'hABCD,     32'h0},
    {1'b0, 4'd7, 6'h08, 32'h0,        32'h0},        // R7
    {1'b1, 4'd8, 6'h20, 32'h5A,       32'h0},
    {1'b1, 4'd8, 6'h10, 32'hFFFFFFFE, 32'h0},
    {1'b0, 4'd8, 6'h10, 32'h0,        32'h7E},       // R8
    {1'b0, 4'd8, 6'h20, 32'h0,        32'h5A}        // R8 no side effect
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    check(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74]) do_write(VEC[i][69:64], VEC[i][63:32]);
      else            do_read(int'(VEC[i][73:70]), VEC[i][69:64], VEC[i][31:0]);
    end

    // R10 interrupt held low
    #1 check(10, {31'b0, irq}, 32'h0);

    // R9 soft reset: index was 12, ind12=CA, ind7=55, regs 3/8/15 nonzero
    do_write(6'h10, 32'h0000_0083);
    do_read(9, 6'h10, 32'h03);
    do_read(9, 6'h00, 32'h0);
    do_read(9, 6'h0C, 32'h0);
    do_read(9, 6'h20, 32'h0);
    do_read(9, 6'h3C, 32'h0);
    do_read(9, 6'h04, 32'h0);
    do_write(6'h00, 32'd7);
    do_read(9, 6'h04, 32'h0);
    do_write(6'h00, 32'd12);
    do_read(9, 6'h04, 32'h8A);
    do_write(6'h00, 32'd25);
    do_read(9, 6'h04, 32'hA0);
    do_write(6'h10, 32'hFFFF_FFFF);
    do_read(9, 6'h10, 32'h7F);

    // R2 write and read in the same cycle: old value, then new
    @(negedge clk);
    addr = 6'h18; wdata = 32'h1111_2222; wr_en = 1'b1; rd_en = 1'b1;
    #1 check(2, rdata, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check(2, rdata, 32'h1111_2222);
    rd_en = 1'b0;

    // R2 read strobe low gives zero
    do_write(6'h0C, 32'h0000_0099);
    @(negedge clk);
    addr = 6'h0C; rd_en = 1'b0;
    #1 check(2, rdata, 32'h0);
    do_read(2, 6'h0C, 32'h99);

    // R1 asynchronous reset mid-run
    do_write(6'h00, 32'd12);
    do_write(6'h04, 32'h40);
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 rst_ni = 1'b1;
    do_read(1, 6'h0C, 32'h0);
    do_read(1, 6'h18, 32'h0);
    do_read(1, 6'h00, 32'h0);
    do_write(6'h00, 32'd12);
    do_read(1, 6'h04, 32'h8A);

    // R10 interrupt still low
    #1 check(10, {31'b0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule